// File: doc/BRIEF.md
# Unlock-Guarded Clock Multiplier Register Bank

This block is the software-facing front end of a clock-multiplier controller. Software writes a control word (enable and connect request) and a configuration word (multiplier and pre-divider, each stored as value minus one). These writes only reach pending holding registers. The outputs that steer the multiplier change only after a two-write unlock on a dedicated key register: first the low byte 0xAA, then 0x55. On that second write the pending values become the active image in a single step.

A status word reports the active image and the lock indication from the multiplier. Software can therefore poll for enable, connect and lock together. A new multiplier or pre-divider value is taken only while the multiplier is disabled. The connect output is held off until the multiplier reports lock.

The bus is a plain word-indexed register port. `bus_addr_i` selects the register: 0 is control, 1 is configuration, 2 is status and 3 is the key register. Reads are combinational from the address. Writes happen on the clock edge while `bus_we_i` is high.

Top module: `pll_feed_regs`

## Requirements
- R1: A write of low byte 0xAA to address 3, followed by a write of low byte 0x55 to address 3, copies the pending control values to the active image on the clock edge of the 0x55 write. The outputs show the new values from that edge on.
- R2: Writes to address 0 or 1 that are not followed by a completed unlock leave `pll_en_o`, `pll_mul_o` and `pll_div_o` unchanged.
- R3: Reading address 2 returns the active image, never values that are only pending. The layout is: bits 14:0 active multiplier-minus-one, bits 23:16 active pre-divider-minus-one, bit 24 active enable, bit 25 active connect request, bit 26 the live `pll_lock_i`.
- R4: In the control word, bit 0 is the enable and bit 1 is the connect request. A value of 1 enables only, and a value of 3 enables and requests connect. Reading address 0 returns the pending control bits.
- R5: In the configuration word, bits 14:0 hold multiplier-minus-one and bits 23:16 hold pre-divider-minus-one. The active fields appear unchanged on `pll_mul_o` and `pll_div_o`, so a stored 35 with 0 means multiply by 36 and divide by 1. Reading address 1 returns the pending fields.
- R6: A completed unlock commits the pending configuration only if the active enable was clear before that unlock. While the active enable is set, the configuration outputs do not change.
- R7: After reset, the active enable, connect request, multiplier and pre-divider are zero, and so are all pending values.
- R8: The unlock aborts in three cases: a key write other than 0xAA or 0x55 follows 0xAA, a 0x55 arrives with no 0xAA before it, or a write to any other address comes between the two key writes. A repeated 0xAA re-arms the sequence. Idle cycles do not abort it.
- R9: `pll_conn_o` is high only when the active enable is set, the active connect request is set and `pll_lock_i` is high.
- R10: Unused bits read as zero. These are bits 31:2 at address 0, bits 31:24 and 15 at address 1, bits 31:27 and 15 at address 2, and every bit at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Word index of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, one write per high cycle |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| pll_lock_i | input | 1 | Lock indication from the multiplier |
| pll_en_o | output | 1 | Active enable |
| pll_conn_o | output | 1 | Connect, gated by enable and lock |
| pll_mul_o | output | 15 | Active multiplier minus one |
| pll_div_o | output | 8 | Active pre-divider minus one |

## Verification
The assertions assume a single-writer bus: one write per cycle with `bus_we_i` high, an address that is always 0 to 3, and inputs that are never unknown after reset. They also take `pll_lock_i` to be a level that can change at any cycle without any handshake with connect. The stimulus drives every write for exactly one cycle between falling edges, and it changes the lock input only while no write is in progress. Every key sequence, valid or aborted, is therefore seen by the design exactly as the bench model sees it.

// File: rtl/pll_feed_pkg.sv
package pll_feed_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int KEY_W    = 8;
    localparam int MUL_W    = 15;
    localparam int DIV_W    = 8;
    localparam int DIV_LSB  = 16;
    localparam int EN_BIT   = 24;
    localparam int CONN_BIT = 25;
    localparam int LOCK_BIT = 26;

    localparam logic [KEY_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [KEY_W-1:0] KEY_SECOND = 8'h55;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_CFG  = 2'd1,
        REG_STAT = 2'd2,
        REG_KEY  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pll_feed_unlock.sv
module pll_feed_unlock
    import pll_feed_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  reg_sel_e         sel_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             fire_o
);
    typedef struct packed {
        logic armed;
    } unlock_st_t;

    unlock_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        if (wr_i) begin
            if (sel_i == REG_KEY) begin
                if (key_i == KEY_FIRST) begin
                    st_d.armed = 1'b1;
                end else if (st_q.armed && key_i == KEY_SECOND) begin
                    fire_o     = 1'b1;
                    st_d.armed = 1'b0;
                end else begin
                    st_d.armed = 1'b0;
                end
            end else begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    abort_on_other_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i != REG_KEY) |=> !st_q.armed);

    // R8
    arm_on_first_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == REG_KEY && key_i == KEY_FIRST) |=> st_q.armed);
endmodule

// File: rtl/pll_feed_image.sv
module pll_feed_image
    import pll_feed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  reg_sel_e          sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              fire_i,
    output logic              pend_en_o,
    output logic              pend_cb_o,
    output logic [MUL_W-1:0]  pend_mul_o,
    output logic [DIV_W-1:0]  pend_div_o,
    output logic              act_en_o,
    output logic              act_cb_o,
    output logic [MUL_W-1:0]  act_mul_o,
    output logic [DIV_W-1:0]  act_div_o
);
    typedef struct packed {
        logic             pend_en;
        logic             pend_cb;
        logic [MUL_W-1:0] pend_mul;
        logic [DIV_W-1:0] pend_div;
        logic             act_en;
        logic             act_cb;
        logic [MUL_W-1:0] act_mul;
        logic [DIV_W-1:0] act_div;
    } image_st_t;

    image_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i && sel_i == REG_CTRL) begin
            st_d.pend_en = wdata_i[0];
            st_d.pend_cb = wdata_i[1];
        end
        if (wr_i && sel_i == REG_CFG) begin
            st_d.pend_mul = wdata_i[MUL_W-1:0];
            st_d.pend_div = wdata_i[DIV_LSB +: DIV_W];
        end
        if (fire_i) begin
            st_d.act_en = st_q.pend_en;
            st_d.act_cb = st_q.pend_cb;
            if (!st_q.act_en) begin
                st_d.act_mul = st_q.pend_mul;
                st_d.act_div = st_q.pend_div;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_en_o  = st_q.pend_en;
    assign pend_cb_o  = st_q.pend_cb;
    assign pend_mul_o = st_q.pend_mul;
    assign pend_div_o = st_q.pend_div;
    assign act_en_o   = st_q.act_en;
    assign act_cb_o   = st_q.act_cb;
    assign act_mul_o  = st_q.act_mul;
    assign act_div_o  = st_q.act_div;

    // R6
    cfg_frozen_while_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.act_en |=> ($stable(st_q.act_mul) && $stable(st_q.act_div)));

    // R1
    image_only_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> ($stable(st_q.act_en) && $stable(st_q.act_cb)));
endmodule

// File: rtl/pll_feed_regs.sv
module pll_feed_regs
    import pll_feed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_we_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              pll_lock_i,
    output logic              pll_en_o,
    output logic              pll_conn_o,
    output logic [MUL_W-1:0]  pll_mul_o,
    output logic [DIV_W-1:0]  pll_div_o
);
    reg_sel_e         sel;
    logic             fire;
    logic             pend_en, pend_cb, act_en, act_cb;
    logic [MUL_W-1:0] pend_mul, act_mul;
    logic [DIV_W-1:0] pend_div, act_div;

    assign sel = reg_sel_e'(bus_addr_i);

    pll_feed_unlock u_unlock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (bus_we_i),
        .sel_i  (sel),
        .key_i  (bus_wdata_i[KEY_W-1:0]),
        .fire_o (fire)
    );

    pll_feed_image u_image (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_we_i),
        .sel_i      (sel),
        .wdata_i    (bus_wdata_i),
        .fire_i     (fire),
        .pend_en_o  (pend_en),
        .pend_cb_o  (pend_cb),
        .pend_mul_o (pend_mul),
        .pend_div_o (pend_div),
        .act_en_o   (act_en),
        .act_cb_o   (act_cb),
        .act_mul_o  (act_mul),
        .act_div_o  (act_div)
    );

    always_comb begin
        bus_rdata_o = '0;
        unique case (sel)
            REG_CTRL: begin
                bus_rdata_o[0] = pend_en;
                bus_rdata_o[1] = pend_cb;
            end
            REG_CFG: begin
                bus_rdata_o[MUL_W-1:0]        = pend_mul;
                bus_rdata_o[DIV_LSB +: DIV_W] = pend_div;
            end
            REG_STAT: begin
                bus_rdata_o[MUL_W-1:0]        = act_mul;
                bus_rdata_o[DIV_LSB +: DIV_W] = act_div;
                bus_rdata_o[EN_BIT]           = act_en;
                bus_rdata_o[CONN_BIT]         = act_cb;
                bus_rdata_o[LOCK_BIT]         = pll_lock_i;
            end
            default: bus_rdata_o = '0;
        endcase
    end

    assign pll_en_o   = act_en;
    assign pll_mul_o  = act_mul;
    assign pll_div_o  = act_div;
    assign pll_conn_o = act_en & act_cb & pll_lock_i;

    // R9
    conn_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_conn_o |-> (pll_en_o && pll_lock_i));

    // R2
    outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we_i && sel == REG_KEY && bus_wdata_i[KEY_W-1:0] == KEY_SECOND)
        |=> ($stable(pll_en_o) && $stable(pll_mul_o) && $stable(pll_div_o)));

    // R3
    status_matches_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_STAT) |-> (bus_rdata_o[EN_BIT] == pll_en_o
                               && bus_rdata_o[MUL_W-1:0] == pll_mul_o
                               && bus_rdata_o[DIV_LSB +: DIV_W] == pll_div_o));
endmodule

// File: tb/pll_feed_regs_tb.sv
`timescale 1ns/1ps
module pll_feed_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        lock = 1'b0;
    logic        pll_en, pll_conn;
    logic [14:0] pll_mul;
    logic [7:0]  pll_div;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model, built from the requirements
    bit        m_armed = 0;
    bit        p_en = 0, p_cb = 0, a_en = 0, a_cb = 0;
    bit [14:0] p_mul = 0, a_mul = 0;
    bit [7:0]  p_div = 0, a_div = 0;

    always #2.5 clk = ~clk;

    pll_feed_regs dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_we_i    (bus_we),
        .bus_rdata_o (bus_rdata),
        .pll_lock_i  (lock),
        .pll_en_o    (pll_en),
        .pll_conn_o  (pll_conn),
        .pll_mul_o   (pll_mul),
        .pll_div_o   (pll_div)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_wr(input logic [1:0] a, input logic [31:0] d);
        if (a == 2'd3) begin
            if (d[7:0] == 8'hAA) m_armed = 1;
            else if (m_armed && d[7:0] == 8'h55) begin
                if (!a_en) begin a_mul = p_mul; a_div = p_div; end
                a_en = p_en; a_cb = p_cb; m_armed = 0;
            end else m_armed = 0;
        end else begin
            m_armed = 0;
            if (a == 2'd0) begin p_en = d[0]; p_cb = d[1]; end
            if (a == 2'd1) begin p_mul = d[14:0]; p_div = d[23:16]; end
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] r;
        chk({tag, " R1 en"}, {31'b0, pll_en}, {31'b0, a_en});
        chk({tag, " R5 mul"}, {17'b0, pll_mul}, {17'b0, a_mul});
        chk({tag, " R5 div"}, {24'b0, pll_div}, {24'b0, a_div});
        chk({tag, " R9 conn"}, {31'b0, pll_conn}, {31'b0, a_en & a_cb & lock});
        rd(2'd2, r);
        chk({tag, " R3 status"}, r, {5'b0, lock, a_cb, a_en, a_div, 1'b0, a_mul});
        rd(2'd0, r);
        chk({tag, " R4 ctrl"}, r, {30'b0, p_cb, p_en});
        rd(2'd1, r);
        chk({tag, " R5 cfg"}, r, {8'b0, p_div, 1'b0, p_mul});
        rd(2'd3, r);
        chk({tag, " R10 key"}, r, 32'h0);
    endtask

    task automatic feed();
        wr(2'd3, 32'hAA);
        wr(2'd3, 32'h55);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R7 reset");

        // R2: pending only, no unlock
        wr(2'd1, 32'h0000_0023);
        wr(2'd0, 32'h3);
        check_all("R2 no feed");

        // R1 R4 R5: documented example, enable then connect after lock
        feed();
        check_all("R1 enable m36 n1");
        lock = 1'b1; #0.5;
        check_all("R9 locked");
        wr(2'd0, 32'h0); feed();

        // R1 R5 R9: sweep control values and configurations
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 8; k++) begin
                logic [31:0] cfg;
                cfg = ((k * 4099 + 35) & 32'h7FFF) | (((k * 37) & 32'hFF) << 16);
                wr(2'd0, 32'h0); feed();
                wr(2'd1, cfg);
                wr(2'd0, c);
                feed();
                for (int l = 0; l < 2; l++) begin
                    @(negedge clk); lock = l[0]; #0.5;
                    check_all("R1 sweep");
                end
            end
        end

        // R6: config change while enabled is dropped
        wr(2'd0, 32'h1); feed();
        wr(2'd1, 32'h0042_0123);
        wr(2'd0, 32'h3);
        feed();
        check_all("R6 enabled cfg");

        // R8: aborts
        wr(2'd0, 32'h0);
        wr(2'd3, 32'hAA); wr(2'd3, 32'h12); wr(2'd3, 32'h55);
        check_all("R8 bad key");
        wr(2'd3, 32'hAA); wr(2'd0, 32'h0); wr(2'd3, 32'h55);
        check_all("R8 other write");
        wr(2'd3, 32'h55);
        check_all("R8 lone second");
        wr(2'd3, 32'hAA); wr(2'd3, 32'hAA);
        repeat (4) @(negedge clk);
        wr(2'd3, 32'h55);
        check_all("R8 rearm idle");

        // R10: unused bits
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'hFFFF_FFFF);
        check_all("R10 ones");
        feed();
        check_all("R10 ones fed");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule